// File: doc/BRIEF.md
# Byte/Word Arithmetic Logic Unit with Status Register

This block computes one arithmetic or logical result per cycle on 16-bit operands, or on their low 8 bits when byte size is selected. It covers addition and subtraction, with or without the stored carry, three bitwise operations, and a compare. The result comes out combinationally from the operands and operation code.

The six condition flags derived from that result are captured in a 16-bit status register on the next clock edge, but only when the caller enables the update. The same register holds three control bits: single-step trap, interrupt enable and string direction. Dedicated set and clear strobes change these bits, and no ALU result ever touches them.

The surrounding datapath supplies operands from its own register file. It reads the status register back to steer branches and to feed the stored carry into multi-precision chains.

Top module: `alu_core`

## Requirements
- R1: The operation code `op_i` selects 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR and 7 compare. `result_o` follows the inputs in the same cycle.
- R2: With `word_i`=0, only operand bits 7:0 take part and `result_o[15:8]` is zero. In this mode CF, OF and SF come from bit 7 and ZF is judged on 8 bits. With `word_i`=1, all 16 bits are used.
- R3: For arithmetic operations, CF (bit 0) is the carry out of the top bit on add, or the borrow on subtract. Add-with-carry and subtract-with-borrow add or subtract the stored CF. OF (bit 11) is set on two's-complement overflow.
- R4: AF (bit 4) is set when an arithmetic operation carries or borrows from bit 3 into bit 4.
- R5: PF (bit 2) is set when `result` bits 7:0 hold an even number of ones, in both sizes. ZF (bit 6) is set when the sized result is zero. SF (bit 7) copies the sized result's top bit.
- R6: AND, OR and XOR clear CF and OF and leave AF at its previous value. They set PF, ZF and SF from the result.
- R7: Compare drives `result_o` to zero and loads the condition flags exactly as subtract would.
- R8: The condition flags change only on a rising clock edge with `flag_we_i`=1. Otherwise they hold.
- R9: The control bits sit at TF bit 8, IF bit 9 and DF bit 10. Strobe vectors `ctl_set_i`/`ctl_clr_i` map bit 0 to TF, bit 1 to IF and bit 2 to DF. They act on any clock edge, and clear wins over set. ALU operations and `flag_we_i` never change these bits.
- R10: Status bits 1, 3, 5 and 12-15 read zero. An active-low `rst_n` clears the whole register asynchronously, and its release takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| a_i | input | 16 | First operand (destination side) |
| b_i | input | 16 | Second operand (source side) |
| flag_we_i | input | 1 | Load condition flags at this edge |
| ctl_set_i | input | 3 | Set strobes for TF, IF, DF |
| ctl_clr_i | input | 3 | Clear strobes for TF, IF, DF |
| result_o | output | 16 | Operation result |
| flags_o | output | 16 | Status register |

## Verification
Additions are run at the signed boundary 0x7FFF+1 and at the unsigned wrap 0xFFFF+1. These separate overflow from carry and show the nibble carry. Subtracting 1 from 0, followed by a borrow-chained subtract, shows borrow handling and use of the stored CF. Word operands whose high byte holds ones while the low byte is even or odd show that parity looks only at the low byte. The same operands run in byte mode show that bit 7 drives CF, SF and OF and that the upper byte is ignored. Logical operations issued after an AF-setting add tell "AF kept" apart from "AF cleared". Runs with the update enable low, and with set and clear strobes together, check that the register holds and that clear has priority.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  localparam int STAT_W = 16;
  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int TF_B = 8;
  localparam int IF_B = 9;
  localparam int DF_B = 10;
  localparam int OF_B = 11;
  localparam int CTL_N = 3;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } cond_t;
endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e             op,
  input  logic                word,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                cf_in,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W-1:0]   flag_res,
  output logic                cf,
  output logic                af,
  output logic                of,
  output logic                is_logic
);
  localparam int HALF = DATA_W / 2;

  logic              sub, use_c, cin;
  logic [DATA_W-1:0] bx, lres, ares;
  logic [DATA_W:0]   sum_w;
  logic [HALF:0]     sum_b;
  logic [4:0]        nib;
  logic              a_m, b_m, r_m;

  always_comb begin
    sub      = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    use_c    = (op == OP_ADC) || (op == OP_SBB);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    bx       = sub ? ~b : b;
    cin      = use_c ? (cf_in ^ sub) : sub;
    sum_w    = {1'b0, a} + {1'b0, bx} + {{DATA_W{1'b0}}, cin};
    sum_b    = {1'b0, a[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, cin};
    nib      = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'b0, cin};
    ares     = word ? sum_w[DATA_W-1:0] : {{HALF{1'b0}}, sum_b[HALF-1:0]};
    a_m      = word ? a[DATA_W-1]  : a[HALF-1];
    b_m      = word ? bx[DATA_W-1] : bx[HALF-1];
    r_m      = word ? ares[DATA_W-1] : ares[HALF-1];
    cf       = (word ? sum_w[DATA_W] : sum_b[HALF]) ^ sub;
    af       = nib[4] ^ sub;
    of       = (a_m == b_m) && (r_m != a_m);
    unique case (op)
      OP_AND:  lres = a & b;
      OP_OR:   lres = a | b;
      default: lres = a ^ b;
    endcase
    if (!word) lres[DATA_W-1:HALF] = '0;
    flag_res = is_logic ? lres : ares;
    res      = (op == OP_CMP) ? '0 : flag_res;
  end
endmodule

// File: rtl/alu_condflags.sv
`timescale 1ns/1ps
module alu_condflags
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] flag_res,
  input  logic              word,
  input  logic              cf,
  input  logic              af,
  input  logic              of,
  input  logic              is_logic,
  input  logic              af_old,
  output cond_t             cond
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    cond.pf = ~^flag_res[7:0];
    cond.zf = word ? (flag_res == '0) : (flag_res[HALF-1:0] == '0);
    cond.sf = word ? flag_res[DATA_W-1] : flag_res[HALF-1];
    cond.cf = is_logic ? 1'b0 : cf;
    cond.of = is_logic ? 1'b0 : of;
    cond.af = is_logic ? af_old : af;
  end
endmodule

// File: rtl/alu_flagreg.sv
`timescale 1ns/1ps
module alu_flagreg
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  cond_t             cond,
  input  logic [CTL_N-1:0]  ctl_set,
  input  logic [CTL_N-1:0]  ctl_clr,
  output logic [STAT_W-1:0] flags
);
  logic [STAT_W-1:0] flags_q, flags_d;
  logic [CTL_N-1:0]  ctl_q, ctl_d;
  cond_t             cond_q, cond_d;

  always_comb begin
    cond_d = we ? cond : cond_q;
    for (int i = 0; i < CTL_N; i++) begin
      if (ctl_clr[i])      ctl_d[i] = 1'b0;
      else if (ctl_set[i]) ctl_d[i] = 1'b1;
      else                 ctl_d[i] = ctl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ctl_q  <= '0;
    end else begin
      cond_q <= cond_d;
      ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    flags_q       = '0;
    flags_q[CF_B] = cond_q.cf;
    flags_q[PF_B] = cond_q.pf;
    flags_q[AF_B] = cond_q.af;
    flags_q[ZF_B] = cond_q.zf;
    flags_q[SF_B] = cond_q.sf;
    flags_q[OF_B] = cond_q.of;
    flags_q[TF_B] = ctl_q[0];
    flags_q[IF_B] = ctl_q[1];
    flags_q[DF_B] = ctl_q[2];
    flags         = flags_q;
  end

  // Condition bits hold when no update is requested
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({flags[OF_B], flags[SF_B], flags[ZF_B], flags[AF_B], flags[PF_B], flags[CF_B]}));

  // Control bits move only under a strobe
  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[DF_B:TF_B]));

  // Clear has priority over set
  assert_ctl_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr[1]) |=> !flags[IF_B]);
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              flag_we_i,
  input  logic [2:0]        ctl_set_i,
  input  logic [2:0]        ctl_clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic [15:0]       flags_o
);
  localparam int HALF = DATA_W / 2;

  logic              rs_q1, rs_q2;
  alu_op_e           op;
  logic [DATA_W-1:0] flag_res;
  logic              a_cf, a_af, a_of, is_logic;
  cond_t             cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  assign op = alu_op_e'(op_i);

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op), .word(word_i), .a(a_i), .b(b_i), .cf_in(flags_o[CF_B]),
    .res(result_o), .flag_res(flag_res), .cf(a_cf), .af(a_af), .of(a_of),
    .is_logic(is_logic)
  );

  alu_condflags #(.DATA_W(DATA_W)) u_cond (
    .flag_res(flag_res), .word(word_i), .cf(a_cf), .af(a_af), .of(a_of),
    .is_logic(is_logic), .af_old(flags_o[AF_B]), .cond(cond)
  );

  alu_flagreg u_freg (
    .clk(clk), .rst_n(rs_q2), .we(flag_we_i), .cond(cond),
    .ctl_set(ctl_set_i), .ctl_clr(ctl_clr_i), .flags(flags_o)
  );

  // Logical ops clear CF/OF and keep AF
  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rs_q2)
    (flag_we_i && is_logic) |=> (!flags_o[CF_B] && !flags_o[OF_B] &&
                                 flags_o[AF_B] == $past(flags_o[AF_B])));

  // ZF agrees with the sized result of the previous non-compare op
  assert_zero_R5: assert property (@(posedge clk) disable iff (!rs_q2)
    (flag_we_i && op != OP_CMP) |=> flags_o[ZF_B] ==
      ($past(word_i) ? ($past(result_o) == '0) : ($past(result_o[HALF-1:0]) == '0)));

  // Byte mode leaves the upper result byte empty
  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (!rs_q2)
    !word_i |-> result_o[DATA_W-1:HALF] == '0);

  // Compare produces no result
  assert_cmp_zero_R7: assert property (@(posedge clk) disable iff (!rs_q2)
    (op == OP_CMP) |-> result_o == '0);

  // Undefined status bits stay zero
  assert_unused_R10: assert property (@(posedge clk) disable iff (!rs_q2)
    flag_we_i |=> (flags_o & 16'hF02A) == 16'h0);
endmodule

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic        word_i;
  logic [15:0] a_i, b_i;
  logic        flag_we_i;
  logic [2:0]  ctl_set_i, ctl_clr_i;
  logic [15:0] result_o, flags_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mflags;

  always #2.5 clk = ~clk;

  alu_core u_alu_core (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .word_i(word_i), .a_i(a_i), .b_i(b_i),
    .flag_we_i(flag_we_i), .ctl_set_i(ctl_set_i), .ctl_clr_i(ctl_clr_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Reference: integer arithmetic from the requirements
  function automatic logic [31:0] model(input int op, input logic word,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] fl);
    int n, mask, ai, bi, cc, r, sa, sb, sr, lo, hi;
    logic cf, af, of, zf, sf, pf;
    logic [15:0] nf, res;
    n = word ? 16 : 8;
    mask = (1 << n) - 1;
    ai = int'(a) & mask;
    bi = int'(b) & mask;
    sa = (ai >= (1 << (n-1))) ? ai - (1 << n) : ai;
    sb = (bi >= (1 << (n-1))) ? bi - (1 << n) : bi;
    lo = -(1 << (n-1));
    hi = (1 << (n-1)) - 1;
    cf = 0; af = fl[4]; of = 0; r = 0;
    if (op <= 1) begin
      cc = (op == 1) ? int'(fl[0]) : 0;
      r = ai + bi + cc;
      cf = r > mask;
      af = ((ai & 15) + (bi & 15) + cc) > 15;
      sr = sa + sb + cc;
      of = (sr > hi) || (sr < lo);
    end else if (op == 2 || op == 3 || op == 7) begin
      cc = (op == 3) ? int'(fl[0]) : 0;
      r = ai - bi - cc;
      cf = r < 0;
      af = ((ai & 15) - (bi & 15) - cc) < 0;
      sr = sa - sb - cc;
      of = (sr > hi) || (sr < lo);
    end else if (op == 4) r = ai & bi;
    else if (op == 5) r = ai | bi;
    else r = ai ^ bi;
    r = r & mask;
    zf = (r == 0);
    sf = ((r >> (n-1)) & 1) == 1;
    pf = ($countones(r & 255) % 2) == 0;
    nf = fl;
    nf[0] = cf; nf[2] = pf; nf[4] = af; nf[6] = zf; nf[7] = sf; nf[11] = of;
    res = (op == 7) ? 16'h0 : r[15:0];
    return {res, nf};
  endfunction

  task automatic step(input int op, input logic word, input logic [15:0] a,
      input logic [15:0] b, input logic we, input logic [2:0] set, input logic [2:0] clr,
      input string tag);
    logic [31:0] m;
    @(negedge clk);
    op_i = op[2:0]; word_i = word; a_i = a; b_i = b;
    flag_we_i = we; ctl_set_i = set; ctl_clr_i = clr;
    m = model(op, word, a, b, mflags);
    #1 chk({tag, " result"}, result_o, m[31:16]);
    if (we) mflags = m[15:0];
    for (int i = 0; i < 3; i++) begin
      if (clr[i]) mflags[8+i] = 1'b0;
      else if (set[i]) mflags[8+i] = 1'b1;
    end
    @(posedge clk);
    #1 flag_we_i = 1'b0; ctl_set_i = '0; ctl_clr_i = '0;
    @(negedge clk);
    chk({tag, " flags"}, flags_o, mflags);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    mflags = '0;
  endtask

  task automatic t_reset();       // R10
    @(negedge clk);
    chk("R10 reset state", flags_o, 16'h0000);
  endtask

  task automatic t_add();         // R1 R3 R4
    step(0, 1, 16'h7FFF, 16'h0001, 1, 0, 0, "R3 add signed overflow");
    chk("R4 af nibble carry", {15'h0, flags_o[4]}, 16'h1);
    step(0, 1, 16'hFFFF, 16'h0001, 1, 0, 0, "R3 add carry wrap");
    chk("R3 cf set", {15'h0, flags_o[0]}, 16'h1);
    step(1, 1, 16'h0001, 16'h0001, 1, 0, 0, "R1 adc with cf");
    step(0, 1, 16'h1234, 16'h4321, 1, 0, 0, "R1 add plain");
  endtask

  task automatic t_sub();         // R1 R3 R4
    step(2, 1, 16'h0000, 16'h0001, 1, 0, 0, "R3 sub borrow");
    step(3, 1, 16'h0010, 16'h0005, 1, 0, 0, "R3 sbb with borrow");
    step(2, 1, 16'h8000, 16'h0001, 1, 0, 0, "R3 sub signed overflow");
    step(2, 1, 16'h0050, 16'h0050, 1, 0, 0, "R1 sub to zero");
  endtask

  task automatic t_parity();      // R5
    step(0, 1, 16'h0100, 16'h0000, 1, 0, 0, "R5 parity low byte even");
    chk("R5 pf set", {15'h0, flags_o[2]}, 16'h1);
    step(0, 1, 16'h0301, 16'h0000, 1, 0, 0, "R5 parity low byte odd");
    chk("R5 pf clear", {15'h0, flags_o[2]}, 16'h0);
  endtask

  task automatic t_byte();        // R2
    step(0, 0, 16'h12FF, 16'h3401, 1, 0, 0, "R2 byte wrap");
    chk("R2 byte zf", {15'h0, flags_o[6]}, 16'h1);
    step(0, 0, 16'hAA7F, 16'h0001, 1, 0, 0, "R2 byte overflow");
    step(2, 0, 16'h0100, 16'h0001, 1, 0, 0, "R2 byte borrow");
  endtask

  task automatic t_logic();       // R6
    step(0, 1, 16'h000F, 16'h0001, 1, 0, 0, "R4 set af");
    step(6, 1, 16'hF0F0, 16'hFF00, 1, 0, 0, "R6 xor keeps af");
    chk("R6 af kept", {15'h0, flags_o[4]}, 16'h1);
    step(4, 1, 16'hF0F0, 16'h0F0F, 1, 0, 0, "R6 and zero");
    step(5, 0, 16'hFF80, 16'h0001, 1, 0, 0, "R6 or byte");
  endtask

  task automatic t_cmp();         // R7
    step(7, 1, 16'h0003, 16'h0005, 1, 0, 0, "R7 compare less");
    step(7, 1, 16'h4444, 16'h4444, 1, 0, 0, "R7 compare equal");
  endtask

  task automatic t_hold();        // R8
    step(0, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R8 no update");
    step(4, 1, 16'h0000, 16'h0000, 0, 0, 0, "R8 no update logic");
  endtask

  task automatic t_ctl();         // R9
    step(0, 1, 16'h0000, 16'h0000, 0, 3'b111, 0, "R9 set all ctl");
    step(0, 1, 16'h0000, 16'h0000, 0, 0, 3'b010, "R9 clear if");
    step(0, 1, 16'h0000, 16'h0000, 0, 3'b001, 3'b001, "R9 clear wins");
    step(2, 1, 16'h0000, 16'h0001, 1, 0, 0, "R9 alu leaves ctl");
    chk("R9 df kept", {15'h0, flags_o[10]}, 16'h1);
  endtask

  task automatic t_midreset();    // R10
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R10 async clear", flags_o, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    mflags = '0;
    step(0, 1, 16'h0001, 16'h0002, 1, 0, 0, "R10 after reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    op_i = '0; word_i = 1'b1; a_i = '0; b_i = '0;
    flag_we_i = 1'b0; ctl_set_i = '0; ctl_clr_i = '0;
    mflags = '0;
    do_reset();
    t_reset();
    t_add();
    t_sub();
    t_parity();
    t_byte();
    t_logic();
    t_cmp();
    t_hold();
    t_ctl();
    t_midreset();
    summary();
    $finish;
  end
endmodule